// File: doc/BRIEF.md
# Shared Bus Arbiter with Global Lock

This block shares one bus among N masters (processor cores, DMA-capable devices, message sources). Each master raises its request line with one transaction's fields (address, write data, write flag and a flag that marks a non-memory message such as an interrupt delivery) and holds them until the bus reports completion. The arbiter picks one master at a time. The bus returns a completion pulse, and the arbiter routes that pulse back to the granted master.

A master that needs an atomic read-modify-write sequence raises its lock line. The arbiter samples the lock line only from the granted master, in the cycle its transaction completes. If the lock line is high, the arbiter pins the bus to that master: every other master waits, including message traffic, until the holder completes a transaction with its lock line low. There is one global lock, so no lock-ordering deadlock can arise. A lock-busy output tells every master that the bus is held. A watchdog flags a lock that has been held longer than a programmable number of cycles.

Top module: `shared_bus_lock_arb`

## Requirements
- R1: While reset is low and in the first cycle after it, grant, done, bus_valid, lock_busy and lock_timeout are all zero and the bus field outputs are zero.
- R2: At most one bit of grant is high in any cycle. Bit i of grant, done, req and lock_req belongs to master i.
- R3: When the bus is free and not locked, the arbiter grants the first requesting master found by scanning upward (with wrap-around) from the index after the last master whose transaction completed. After reset the scan starts at master 0. The grant rises one cycle after the cycle in which the request is seen.
- R4: A grant stays unchanged until bus_done is high. In that cycle done carries the grant bit. In the next cycle grant is zero, so every transaction is followed by at least one cycle with no grant.
- R5: If lock_req of the granted master is high in its completion cycle, lock_busy is high from the next cycle onward.
- R6: lock_req of a master that is not granted has no effect on lock_busy or on which master is granted.
- R7: While lock_busy is high, no master other than the holder is granted, whether its request is a memory access or a message (bus_msg = 1). The holder is granted one cycle after it raises req.
- R8: When the holder completes a transaction with lock_req low, lock_busy is low in the next cycle. Round-robin arbitration runs in that same cycle, and the winner is granted in the cycle after.
- R9: lock_timeout is high exactly in the (lock_limit+1)-th and later consecutive cycles of lock_busy. It is low whenever lock_busy is low.
- R10: bus_valid is high exactly when a grant is active. While a grant is active, bus_addr, bus_wdata, bus_write and bus_msg carry the granted master's slice (m_addr[i*AW +: AW], m_wdata[i*DW +: DW], m_write[i], m_msg[i]). With no grant they are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Per-master transaction request, held until done |
| lock_req | input | N | Per-master lock request, sampled only from the granted master |
| m_addr | input | N*AW | Per-master address, packed by master index |
| m_wdata | input | N*DW | Per-master write data, packed by master index |
| m_write | input | N | Per-master write flag |
| m_msg | input | N | Per-master flag marking a non-memory message |
| bus_done | input | 1 | Completion pulse from the bus for the current transaction |
| lock_limit | input | WW | Lock hold limit in cycles for the watchdog |
| grant | output | N | One-hot grant |
| done | output | N | Completion routed to the granted master |
| bus_valid | output | 1 | A transaction is on the bus |
| bus_addr | output | AW | Address of the granted master |
| bus_wdata | output | DW | Write data of the granted master |
| bus_write | output | 1 | Write flag of the granted master |
| bus_msg | output | 1 | Message flag of the granted master |
| lock_busy | output | 1 | Global lock is held |
| lock_timeout | output | 1 | Lock held beyond lock_limit cycles |

## Verification
Directed sequences first set a lock request on a master that is not granted, which shows whether lock is sampled from the owner alone. They then hold a lock while another master presents a message, which shows whether message traffic is blocked along with memory traffic. A short-limit lock hold checks the exact cycle at which the watchdog fires. A long random phase follows, with bursty requests, randomly toggled lock lines, random completion delay and a changing watchdog limit, all checked cycle by cycle against a bench model. It separates a correct round-robin scan from a fixed-priority one, release at completion from early release, and correct field routing from a wrong index.

// File: rtl/arb_lock_pkg.sv
package arb_lock_pkg;
   // Upper bound on masters accepted by the arbiter
   localparam int unsigned ARB_MAX_MASTERS = 64;

   // Index width for n masters, never below one bit
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] start,
   output logic          any,
   output logic [IW-1:0] win
);
   // scan upward from start with wrap-around; first request wins
   always_comb begin
      any = 1'b0;
      win = start;
      for (int k = 0; k < int'(N); k++) begin
         int t;
         t = int'(start) + k;
         if (t >= int'(N)) t = t - int'(N);
         if (!any && req[t]) begin
            any = 1'b1;
            win = IW'(t);
         end
      end
   end
endmodule

// File: rtl/arb_lock_wdog.sv
module arb_lock_wdog #(
   parameter int unsigned WW     = 8,
   parameter bit          ENABLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          held,
   input  logic [WW-1:0] limit,
   output logic          expired
);
   localparam logic [WW-1:0] CNT_MAX = {WW{1'b1}};

   generate
      if (ENABLE) begin : g_count
         logic [WW-1:0] hold_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !held) hold_cnt <= '0;
            else if (hold_cnt != CNT_MAX) hold_cnt <= hold_cnt + 1'b1;
         end
         assign expired = held && (hold_cnt >= limit);
      end else begin : g_off
         assign expired = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/arb_bus_mux.sv
module arb_bus_mux #(
   parameter int unsigned N  = 4,
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input  logic [N-1:0]    sel,
   input  logic [N*AW-1:0] in_addr,
   input  logic [N*DW-1:0] in_wdata,
   input  logic [N-1:0]    in_write,
   input  logic [N-1:0]    in_msg,
   output logic [AW-1:0]   out_addr,
   output logic [DW-1:0]   out_wdata,
   output logic            out_write,
   output logic            out_msg
);
   logic [AW-1:0] addr_m  [N];
   logic [DW-1:0] wdata_m [N];

   // one-hot AND-OR select, zero when nothing is selected
   generate
      for (genvar g = 0; g < int'(N); g++) begin : g_slice
         assign addr_m[g]  = sel[g] ? in_addr[g*AW +: AW]  : '0;
         assign wdata_m[g] = sel[g] ? in_wdata[g*DW +: DW] : '0;
      end
   endgenerate

   always_comb begin
      out_addr  = '0;
      out_wdata = '0;
      for (int k = 0; k < int'(N); k++) begin
         out_addr  = out_addr  | addr_m[k];
         out_wdata = out_wdata | wdata_m[k];
      end
   end

   assign out_write = |(sel & in_write);
   assign out_msg   = |(sel & in_msg);
endmodule

// File: rtl/shared_bus_lock_arb.sv
module shared_bus_lock_arb #(
   parameter int unsigned N        = 4,
   parameter int unsigned AW       = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned WW       = 8,
   parameter bit          WDOG_ON  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req,
   input  logic [N-1:0]    lock_req,
   input  logic [N*AW-1:0] m_addr,
   input  logic [N*DW-1:0] m_wdata,
   input  logic [N-1:0]    m_write,
   input  logic [N-1:0]    m_msg,
   input  logic            bus_done,
   input  logic [WW-1:0]   lock_limit,
   output logic [N-1:0]    grant,
   output logic [N-1:0]    done,
   output logic            bus_valid,
   output logic [AW-1:0]   bus_addr,
   output logic [DW-1:0]   bus_wdata,
   output logic            bus_write,
   output logic            bus_msg,
   output logic            lock_busy,
   output logic            lock_timeout
);
   import arb_lock_pkg::*;

   localparam int unsigned   IW   = idx_width(N);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   generate
      if (N < 2 || N > ARB_MAX_MASTERS) begin : g_bad_n
         $error("shared_bus_lock_arb: N out of range");
      end
      if (AW < 1 || DW < 1 || WW < 1) begin : g_bad_w
         $error("shared_bus_lock_arb: widths must be positive");
      end
   endgenerate

   logic          busy_q;
   logic          locked_q;
   logic [IW-1:0] owner_q;
   logic [IW-1:0] scan_q;
   logic          pick_any;
   logic [IW-1:0] pick_idx;

   arb_rr_pick #(.N(N), .IW(IW)) pick_i (
      .req   (req),
      .start (scan_q),
      .any   (pick_any),
      .win   (pick_idx)
   );

   // ownership: grant only between transactions, lock sampled at completion
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         locked_q <= 1'b0;
         owner_q  <= '0;
         scan_q   <= '0;
      end else if (!busy_q) begin
         if (locked_q) begin
            if (req[owner_q]) busy_q <= 1'b1;
         end else if (pick_any) begin
            busy_q  <= 1'b1;
            owner_q <= pick_idx;
         end
      end else if (bus_done) begin
         busy_q   <= 1'b0;
         locked_q <= lock_req[owner_q];
         scan_q   <= (owner_q == LAST) ? '0 : owner_q + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < int'(N); g++) begin : g_gnt
         assign grant[g] = busy_q && (owner_q == IW'(g));
      end
   endgenerate

   assign done      = grant & {N{bus_done}};
   assign bus_valid = busy_q;
   assign lock_busy = locked_q;

   arb_bus_mux #(.N(N), .AW(AW), .DW(DW)) mux_i (
      .sel       (grant),
      .in_addr   (m_addr),
      .in_wdata  (m_wdata),
      .in_write  (m_write),
      .in_msg    (m_msg),
      .out_addr  (bus_addr),
      .out_wdata (bus_wdata),
      .out_write (bus_write),
      .out_msg   (bus_msg)
   );

   arb_lock_wdog #(.WW(WW), .ENABLE(WDOG_ON)) wdog_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .held    (locked_q),
      .limit   (lock_limit),
      .expired (lock_timeout)
   );
endmodule

// File: rtl/arb_lock_chk.sv
module arb_lock_chk #(
   parameter int unsigned N = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] lock_req,
   input logic [N-1:0] grant,
   input logic [N-1:0] done,
   input logic         bus_done,
   input logic         bus_valid,
   input logic         lock_busy,
   input logic         lock_timeout
);
   logic [N-1:0] last_done;
   always_ff @(posedge clk) begin
      if (!rst_n) last_done <= '0;
      else if (|done) last_done <= done;
   end

   assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_grant_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant && !bus_done) |=> (grant == $past(grant)));

   assert_gap_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant && bus_done) |=> (grant == '0));

   assert_lock_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(done & lock_req)) |=> lock_busy);

   assert_lock_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_busy && |grant) |-> (grant == last_done));

   assert_lock_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|done && !(|(done & lock_req))) |=> !lock_busy);

   assert_timeout_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_busy |-> !lock_timeout);

   assert_valid_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid == (|grant));
endmodule

bind shared_bus_lock_arb arb_lock_chk #(.N(N)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .lock_req     (lock_req),
   .grant        (grant),
   .done         (done),
   .bus_done     (bus_done),
   .bus_valid    (bus_valid),
   .lock_busy    (lock_busy),
   .lock_timeout (lock_timeout)
);

// File: tb/shared_bus_lock_arb_tb.sv
`timescale 1ns/1ps
module shared_bus_lock_arb_tb_top;
   localparam int N  = 4;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int WW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req = '0;
   logic [N-1:0]    lock_req = '0;
   logic [N*AW-1:0] m_addr = '0;
   logic [N*DW-1:0] m_wdata = '0;
   logic [N-1:0]    m_write = '0;
   logic [N-1:0]    m_msg = '0;
   logic            bus_done = 1'b0;
   logic [WW-1:0]   lock_limit = 8'd200;
   logic [N-1:0]    grant, done;
   logic            bus_valid, bus_write, bus_msg, lock_busy, lock_timeout;
   logic [AW-1:0]   bus_addr;
   logic [DW-1:0]   bus_wdata;

   int checks = 0;
   int errors = 0;

   // model state
   int m_busy = 0, m_owner = 0, m_locked = 0, m_scan = 0, m_cnt = 0;
   int comp = 0, comp_idx = 0;

   always #5 clk = ~clk;

   shared_bus_lock_arb #(.N(N), .AW(AW), .DW(DW), .WW(WW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .lock_req(lock_req),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_write(m_write), .m_msg(m_msg),
      .bus_done(bus_done), .lock_limit(lock_limit), .grant(grant), .done(done),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_write(bus_write), .bus_msg(bus_msg), .lock_busy(lock_busy),
      .lock_timeout(lock_timeout));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v,
                      input string what);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp_v, $time);
      end
   endtask

   function automatic int rr_pick(input int start, input logic [N-1:0] r);
      for (int k = 0; k < N; k++) begin
         int t;
         t = (start + k) % N;
         if (r[t]) return t;
      end
      return -1;
   endfunction

   function automatic logic [N-1:0] exp_grant();
      logic [N-1:0] g;
      g = '0;
      if (m_busy != 0) g[m_owner] = 1'b1;
      return g;
   endfunction

   // next state from the inputs the DUT sees at the coming edge
   task automatic model_next();
      int w;
      comp = 0;
      if (m_locked == 0) m_cnt = 0;
      else if (m_cnt < 255) m_cnt++;
      if (m_busy == 0) begin
         if (m_locked != 0) begin
            if (req[m_owner]) m_busy = 1;
         end else begin
            w = rr_pick(m_scan, req);
            if (w >= 0) begin
               m_busy = 1;
               m_owner = w;
            end
         end
      end else if (bus_done) begin
         m_busy = 0;
         m_scan = (m_owner + 1) % N;
         m_locked = lock_req[m_owner] ? 1 : 0;
         comp = 1;
         comp_idx = m_owner;
      end
   endtask

   task automatic model_check();
      logic [N-1:0] eg;
      eg = exp_grant();
      chk("R2", 64'($countones(grant) <= 1), 64'(1), "grant one-hot");
      chk("R3", 64'(grant), 64'(eg), "grant");
      chk("R4", 64'(done), 64'(eg & {N{bus_done}}), "done");
      chk("R5", 64'(lock_busy), 64'(m_locked != 0), "lock_busy");
      chk("R9", 64'(lock_timeout), 64'((m_locked != 0) && (m_cnt >= int'(lock_limit))),
          "lock_timeout");
      chk("R10", 64'(bus_valid), 64'(m_busy != 0), "bus_valid");
      chk("R10", 64'(bus_addr),
          (m_busy != 0) ? 64'(m_addr[m_owner*AW +: AW]) : 64'(0), "bus_addr");
      chk("R10", 64'(bus_wdata),
          (m_busy != 0) ? 64'(m_wdata[m_owner*DW +: DW]) : 64'(0), "bus_wdata");
      chk("R10", 64'({bus_write, bus_msg}),
          (m_busy != 0) ? 64'({m_write[m_owner], m_msg[m_owner]}) : 64'(0), "write/msg");
   endtask

   task automatic cyc();
      model_next();
      @(posedge clk);
      @(negedge clk);
      model_check();
   endtask

   task automatic new_fields(input int i);
      m_addr[i*AW +: AW]  = $urandom;
      m_wdata[i*DW +: DW] = $urandom;
      m_write[i] = $urandom_range(0, 1);
      m_msg[i]   = ($urandom_range(0, 3) == 0);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < N; i++) new_fields(i);
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", 64'({grant, done, bus_valid, lock_busy, lock_timeout}), 64'(0), "in reset");
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1", 64'({grant, bus_valid, lock_busy, lock_timeout}), 64'(0), "after reset");
      chk("R1", 64'({bus_addr, bus_wdata}), 64'(0), "bus fields after reset");

      // R6: lock from a master that is not granted is ignored
      m_msg = '0;
      req = 4'b0001; lock_req = 4'b0010;
      cyc();
      chk("R6", 64'(grant), 64'(4'b0001), "grant to m0 despite m1 lock");
      bus_done = 1'b1;
      cyc();
      bus_done = 1'b0; req = '0;
      cyc();
      chk("R6", 64'(lock_busy), 64'(0), "non-owner lock ignored");
      lock_req = '0;

      // R7: lock blocks a message from another master
      m_msg[2] = 1'b1;
      req = 4'b0010;
      cyc();
      chk("R7", 64'(grant), 64'(4'b0010), "m1 granted");
      lock_req = 4'b0010; bus_done = 1'b1;
      cyc();
      chk("R5", 64'(lock_busy), 64'(1), "lock taken at completion");
      bus_done = 1'b0; req = 4'b0100;
      for (int k = 0; k < 6; k++) begin
         cyc();
         chk("R7", 64'(grant), 64'(0), "message master blocked");
      end
      req = 4'b0110;
      cyc();
      chk("R7", 64'(grant), 64'(4'b0010), "holder regranted");
      lock_req = '0; bus_done = 1'b1;
      cyc();
      chk("R8", 64'(lock_busy), 64'(0), "lock released at completion");
      bus_done = 1'b0; req = 4'b0100;
      cyc();
      chk("R8", 64'({grant, bus_msg}), 64'({4'b0100, 1'b1}), "arbitration resumed");
      bus_done = 1'b1;
      cyc();
      bus_done = 1'b0; req = '0; m_msg[2] = 1'b0;

      // R9: watchdog fires in cycle lock_limit+1
      lock_limit = 8'd3;
      req = 4'b0001; lock_req = 4'b0001;
      cyc();
      chk("R3", 64'(grant), 64'(4'b0001), "wrap from scan 3 to m0");
      bus_done = 1'b1;
      cyc();
      chk("R9", 64'(lock_timeout), 64'(0), "held cycle 1");
      bus_done = 1'b0; req = '0;
      for (int n = 2; n <= 7; n++) begin
         cyc();
         chk("R9", 64'(lock_timeout), 64'(n >= 4), "held cycle count");
      end
      req = 4'b0001; lock_req = '0;
      cyc();
      bus_done = 1'b1;
      cyc();
      chk("R9", 64'(lock_timeout), 64'(0), "cleared on release");
      bus_done = 1'b0; req = '0;
      cyc();

      // random phase
      for (int c = 0; c < 4000; c++) begin
         if (c % 500 == 0) lock_limit = WW'($urandom_range(0, 12));
         for (int i = 0; i < N; i++) begin
            if (comp != 0 && comp_idx == i) begin
               req[i] = $urandom_range(0, 1);
               if (req[i]) new_fields(i);
            end else if (!req[i] && $urandom_range(0, 3) == 0) begin
               req[i] = 1'b1;
               new_fields(i);
            end
            if ($urandom_range(0, 7) == 0) lock_req[i] = ~lock_req[i];
         end
         bus_done = (m_busy != 0) && ($urandom_range(0, 2) == 0);
         cyc();
      end
      summary();
      $finish;
   end
endmodule